// File: doc/BRIEF.md
# Persistence-Filtered Threshold Interrupt

This block watches the stream of finished light-sensor conversions and decides when to raise an alarm. Each time a conversion completes, the top byte of the 16-bit result is checked against a programmed window formed by two 8-bit limits. The alarm fires only when enough results in a row land outside that window. A short flash or a noise spike therefore does not trip it.

The alarm output is active low on an open-drain pin. The block does not drive the pin level itself. It provides a pull-down enable: when the enable is 1, the pad pulls the line low, and when it is 0, the line is released. Once the alarm is raised it stays raised until software sends a clear pulse. The required run length is picked by a two-bit setting.

Top module: `ptm_threshold_irq`

## Requirements
- R1: During and after reset, `irq_pull_en` is 0 and the consecutive-result count is zero.
- R2: A result is out of window when `res_data[15:8]` is strictly greater than `thr_hi` or strictly less than `thr_lo`. A value equal to either limit is in window, and `res_data[7:0]` has no effect on the decision.
- R3: `persist_sel` sets the run length: 2'b00 needs 1 result, 2'b01 needs 4, 2'b10 needs 8 and 2'b11 needs 16 consecutive out-of-window results.
- R4: An in-window result that arrives while the alarm is not raised sets the consecutive count back to zero.
- R5: Results are evaluated only in cycles where `res_valid` is 1. Changes on `res_data` with `res_valid` at 0 have no effect.
- R6: Once `irq_pull_en` is 1, it stays 1, even through later in-window results, until `flag_clr` is pulsed.
- R7: When `flag_clr` and `res_valid` are both 1 in the same cycle, the clear wins. `irq_pull_en` becomes 0, that result is discarded, and counting restarts from zero.
- R8: `irq_pull_en` becomes 1 in the cycle that follows the strobe carrying the result that completes the required run.
- R9: A `flag_clr` pulse while the alarm is low also resets the partial consecutive count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion-complete strobe, one cycle per result |
| res_data | input | 16 | Conversion result, valid with `res_valid` |
| thr_hi | input | 8 | Upper window limit, compared with the result's top byte |
| thr_lo | input | 8 | Lower window limit, compared with the result's top byte |
| persist_sel | input | 2 | Run-length select (1, 4, 8 or 16 results) |
| flag_clr | input | 1 | Single-cycle pulse that releases the alarm and resets the count |
| irq_pull_en | output | 1 | Pull-down enable for the open-drain active-low alarm pin |

## Verification
Two events can land in the same clock edge: a done strobe carrying an out-of-window result, and a software clear pulse. The bench drives both together in two situations. In the first, the run length is 1, so the result on its own would raise the alarm. In the second, the result would extend a partial run of 3 toward a run length of 4. In both cases the bench expects the alarm to stay low after that edge. It also expects the following results to need the full run again from zero, which shows that the colliding result was thrown away and was not counted.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    typedef enum logic [1:0] {
        PERS_1  = 2'b00,
        PERS_4  = 2'b01,
        PERS_8  = 2'b10,
        PERS_16 = 2'b11
    } pers_sel_e;

    // Consecutive out-of-window results needed for each select code.
    function automatic int unsigned persist_need(input pers_sel_e sel);
        int unsigned n;
        case (sel)
            PERS_1:  n = 1;
            PERS_4:  n = 4;
            PERS_8:  n = 8;
            default: n = 16;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ptm_window_cmp.sv
module ptm_window_cmp #(
    parameter int RES_W = 16,
    parameter int THR_W = 8
) (
    input  logic [RES_W-1:0] res_data,
    input  logic [THR_W-1:0] thr_hi,
    input  logic [THR_W-1:0] thr_lo,
    output logic             out_win
);
    // Only the most significant THR_W bits of the result take part.
    localparam int TOP = RES_W - 1;

    logic [THR_W-1:0] level;
    logic [RES_W-THR_W-1:0] unused_low;

    always_comb begin
        level      = res_data[TOP -: THR_W];
        unused_low = res_data[RES_W-THR_W-1:0];
        out_win    = (level > thr_hi) || (level < thr_lo);
    end

    logic unused_ok;
    assign unused_ok = ^unused_low;

endmodule

// File: rtl/ptm_persist_cnt.sv
module ptm_persist_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             out_win,
    input  logic             clr,
    input  logic [CNT_W-1:0] need,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + CNT_W'(1);
        hit     = 1'b0;
        if (clr) begin
            // Clear takes priority; a coincident result is dropped.
            st_d.cnt = '0;
        end else if (sample) begin
            if (out_win) begin
                if (st_q.cnt < need) begin
                    st_d.cnt = cnt_inc;
                end
                hit = (cnt_inc >= need);
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ptm_irq_latch.sv
module ptm_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.flag = 1'b0;
        end else if (set) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/ptm_threshold_irq.sv
module ptm_threshold_irq #(
    parameter int RES_W  = 16,
    parameter int THR_W  = 8,
    parameter int PSEL_W = 2,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic [THR_W-1:0]  thr_hi,
    input  logic [THR_W-1:0]  thr_lo,
    input  logic [PSEL_W-1:0] persist_sel,
    input  logic              flag_clr,
    output logic              irq_pull_en
);
    import ptm_pkg::*;

    logic             out_win;
    logic             run_hit;
    logic [CNT_W-1:0] need;

    always_comb begin
        need = CNT_W'(persist_need(pers_sel_e'(persist_sel)));
    end

    ptm_window_cmp #(
        .RES_W (RES_W),
        .THR_W (THR_W)
    ) u_cmp (
        .res_data (res_data),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .out_win  (out_win)
    );

    ptm_persist_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (res_valid),
        .out_win (out_win),
        .clr     (flag_clr),
        .need    (need),
        .hit     (run_hit)
    );

    ptm_irq_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (run_hit),
        .clr   (flag_clr),
        .flag  (irq_pull_en)
    );

endmodule

// File: rtl/ptm_threshold_irq_chk.sv
module ptm_threshold_irq_chk #(
    parameter int RES_W  = 16,
    parameter int THR_W  = 8,
    parameter int PSEL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [RES_W-1:0]  res_data,
    input logic [THR_W-1:0]  thr_hi,
    input logic [THR_W-1:0]  thr_lo,
    input logic [PSEL_W-1:0] persist_sel,
    input logic              flag_clr,
    input logic              irq_pull_en
);
    logic [THR_W-1:0] lvl;
    logic             oow;
    always_comb begin
        lvl = res_data[RES_W-1 -: THR_W];
        oow = (lvl > thr_hi) || (lvl < thr_lo);
    end

    a_r6_latched_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_en && !flag_clr |=> irq_pull_en);

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !irq_pull_en);

    a_r5_no_rise_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid && !irq_pull_en |=> !irq_pull_en);

    a_r4_inwindow_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !oow && !irq_pull_en |=> !irq_pull_en);

    a_r3_single_sets: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && oow && !flag_clr && persist_sel == '0 |=> irq_pull_en);

    a_r8_rise_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull_en) |-> $past(res_valid) && !$past(flag_clr));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_low: assert (!irq_pull_en);
        end
    end

endmodule

bind ptm_threshold_irq ptm_threshold_irq_chk #(
    .RES_W  (RES_W),
    .THR_W  (THR_W),
    .PSEL_W (PSEL_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .thr_hi      (thr_hi),
    .thr_lo      (thr_lo),
    .persist_sel (persist_sel),
    .flag_clr    (flag_clr),
    .irq_pull_en (irq_pull_en)
);

// File: tb/ptm_threshold_irq_tb.sv
module ptm_threshold_irq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic [7:0]  thr_hi = 8'h80;
    logic [7:0]  thr_lo = 8'h20;
    logic [1:0]  persist_sel = 2'b00;
    logic        flag_clr = 1'b0;
    logic        irq_pull_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    // Reference state derived from the requirements
    bit ref_flag = 1'b0;
    int ref_cnt  = 0;

    always #4 clk = ~clk;   // 125 MHz

    ptm_threshold_irq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid   (res_valid),
        .res_data    (res_data),
        .thr_hi      (thr_hi),
        .thr_lo      (thr_lo),
        .persist_sel (persist_sel),
        .flag_clr    (flag_clr),
        .irq_pull_en (irq_pull_en)
    );

    function automatic int need_of(input logic [1:0] s);
        case (s)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    task automatic compare(input logic exp, input string tag);
        checks++;
        if (irq_pull_en !== exp) begin
            errors++;
            $display("FAIL %s: irq_pull_en=%b expected=%b", tag, irq_pull_en, exp);
        end
    endtask

    // Monitor: pops one expectation per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            compare(it.exp, it.tag);
        end
    end

    // Driver: one clock of stimulus, then push the expectation
    task automatic step(input logic v, input logic [15:0] d, input logic c, input string tag);
        logic [7:0] lvl;
        @(negedge clk);
        res_valid = v;
        res_data  = d;
        flag_clr  = c;
        lvl = d[15:8];
        if (c) begin
            ref_flag = 1'b0;
            ref_cnt  = 0;
        end else if (v) begin
            if (lvl > thr_hi || lvl < thr_lo) begin
                if (ref_cnt < need_of(persist_sel)) ref_cnt++;
                if (ref_cnt >= need_of(persist_sel)) ref_flag = 1'b1;
            end else begin
                ref_cnt = 0;
            end
        end
        @(posedge clk);
        #1;
        exp_q.push_back('{exp: ref_flag, tag: tag});
        res_valid = 1'b0;
        flag_clr  = 1'b0;
    endtask

    task automatic run_out(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 16'hC000, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare(1'b0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3/R8: single-result mode
        persist_sel = 2'b00;
        step(1'b1, 16'h8100, 1'b0, "R2 R8 above upper");
        step(1'b0, 16'h0000, 1'b1, "R9 clear");
        step(1'b1, 16'h80FF, 1'b0, "R2 equal upper low byte ignored");
        step(1'b1, 16'h2000, 1'b0, "R2 equal lower");
        step(1'b1, 16'h1FFF, 1'b0, "R2 below lower");
        step(1'b0, 16'h0000, 1'b1, "R6 clear releases");

        // R5: data wiggles without strobe
        for (int i = 0; i < 4; i++) step(1'b0, 16'hFF00, 1'b0, "R5 no strobe");

        // R3/R4: run of four
        persist_sel = 2'b01;
        run_out(3, "R3 four partial");
        step(1'b1, 16'h5000, 1'b0, "R4 in-window resets count");
        run_out(3, "R4 restart partial");
        run_out(1, "R3 R8 fourth sets");
        step(1'b1, 16'h5000, 1'b0, "R6 latched in window");
        step(1'b1, 16'h5000, 1'b0, "R6 latched in window");
        step(1'b0, 16'h0000, 1'b1, "R6 clear");

        // R7: collision with clear
        persist_sel = 2'b00;
        step(1'b1, 16'hC000, 1'b1, "R7 clear wins single");
        step(1'b1, 16'hC000, 1'b0, "R7 next result sets");
        step(1'b0, 16'h0000, 1'b1, "R7 clear");
        persist_sel = 2'b01;
        run_out(3, "R7 partial");
        step(1'b1, 16'hC000, 1'b1, "R7 clear wins partial");
        run_out(3, "R7 count restarted");
        run_out(1, "R7 full run sets");
        step(1'b0, 16'h0000, 1'b1, "R7 clear");

        // R9: clear while low wipes partial count
        run_out(2, "R9 partial");
        step(1'b0, 16'h0000, 1'b1, "R9 clear low");
        run_out(3, "R9 restarted");
        step(1'b0, 16'h0000, 1'b1, "R9 clear");

        // R3: eight and sixteen
        persist_sel = 2'b10;
        run_out(7, "R3 eight partial");
        run_out(1, "R3 eighth sets");
        step(1'b0, 16'h0000, 1'b1, "R3 clear");
        persist_sel = 2'b11;
        run_out(15, "R3 sixteen partial");
        run_out(1, "R3 sixteenth sets");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule